// File: doc/BRIEF.md
# Pixel-Period Edge Timing Generator

This block builds the fast clocks that drive a CCD horizontal readout and the sampling front end. It runs from a reference clock at 64 times the pixel rate. A 6-bit phase counter splits every pixel period into 64 slots, numbered 0 to 63, and slot 63 is followed by slot 0. The block then decodes each output from that counter and a set of programmed slot numbers.

The outputs are a reset-gate clock, four horizontal clocks and two one-slot sample strobes. The reset-gate clock and the first two horizontal clocks each have a rising slot, a falling slot and an inverter. The third and fourth horizontal clocks copy the first and second. A pixel-start marker is high during slot 0.

Settings arrive through a single-cycle write port. They are held in a staging copy and move to the live copy only at the change from slot 63 to slot 0, so a pixel period never mixes old and new settings. A divide-by-two enable lets the block accept a reference at twice the rate, so that each slot lasts two reference cycles.

Top module: `pxt_timing_gen`

## Requirements
- R1: `pix_start` is high exactly while the phase counter is at slot 0. The counter counts 0 to 63 and then returns to 0, so there is one marker per 64 slots.
- R2: A synchronous active-high `rst` puts the counter at slot 0 and loads defaults into both the staged and the live settings, with no inversion. The defaults are: reset gate rise 0 and fall 8; H1 rise 0 and fall 32; H2 rise 32 and fall 0; SHP slot 24; SHD slot 56.
- R3: When rise < fall, a clock is high (before inversion) in slots rise through fall-1.
- R4: When rise > fall, the pulse wraps across the pixel boundary: the clock is high in slots rise through 63 and in slots 0 through fall-1.
- R5: When rise == fall, the clock is low before inversion.
- R6: Each of the three clocks has its own polarity bit, written at address 8. Bit 0 belongs to the reset gate, bit 1 to H1 and bit 2 to H2. A set bit inverts the whole output.
- R7: `h3` always equals `h1`, and `h4` always equals `h2`.
- R8: `shp` and `shd` are each high for exactly the one slot equal to their programmed position.
- R9: A write goes to the staged settings. The staged settings are copied to the live settings on the edge that advances the counter from 63 to 0. A write accepted on that same edge lands in the next pixel period, not the current one.
- R10: With `div2_en` high, the counter advances only on every other reference cycle, so each slot lasts two cycles.
- R11: The write address map is: 0/1 reset-gate rise/fall, 2/3 H1 rise/fall, 4/5 H2 rise/fall, 6 SHP, 7 SHD, 8 polarity. Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 64 or 128 times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| div2_en | input | 1 | Halve the slot rate |
| wr_en | input | 1 | Write strobe for staged settings |
| wr_addr | input | 4 | Setting address |
| wr_data | input | 6 | Slot number, or polarity bits [2:0] |
| rg | output | 1 | Reset-gate clock |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Horizontal clock 2 |
| h3 | output | 1 | Copy of h1 |
| h4 | output | 1 | Copy of h2 |
| shp | output | 1 | Reference-level sample strobe |
| shd | output | 1 | Data-level sample strobe |
| pix_start | output | 1 | High during slot 0 |

## Verification
Two functions can fall on the same clock edge: a settings write, and the staged-to-live commit at the 63-to-0 wrap. The bench tracks its own slot count and issues a write to SHP exactly when that count shows slot 63. The result is judged on whether the new strobe position appears one full pixel period later than usual, while the old position stays in force for the coming period. The same commit edge also coincides with edges placed at slot 0 (rise 0, and SHP moved to slot 0). Those outputs are compared every cycle against a reference model.

// File: rtl/pxt_pkg.sv
package pxt_pkg;
    localparam int PHASE_W = 6;
    localparam int NSLOT   = 1 << PHASE_W;
    localparam int NCLK    = 3;
    localparam int ADDR_W  = 4;
    localparam int WV_RG   = 0;
    localparam int WV_H1   = 1;
    localparam int WV_H2   = 2;

    typedef logic [PHASE_W-1:0] pos_t;
    localparam pos_t LAST_POS = pos_t'(NSLOT - 1);

    typedef struct packed {
        pos_t rise;
        pos_t fall;
        logic inv;
    } wave_t;

    typedef struct packed {
        wave_t [NCLK-1:0] wave;
        pos_t             shp;
        pos_t             shd;
    } timing_t;

    typedef enum logic [ADDR_W-1:0] {
        A_RG_RISE = 4'd0,
        A_RG_FALL = 4'd1,
        A_H1_RISE = 4'd2,
        A_H1_FALL = 4'd3,
        A_H2_RISE = 4'd4,
        A_H2_FALL = 4'd5,
        A_SHP     = 4'd6,
        A_SHD     = 4'd7,
        A_POL     = 4'd8
    } reg_addr_e;

    function automatic timing_t reset_timing();
        timing_t t;
        t.wave[WV_RG].rise = pos_t'(0);
        t.wave[WV_RG].fall = pos_t'(8);
        t.wave[WV_RG].inv  = 1'b0;
        t.wave[WV_H1].rise = pos_t'(0);
        t.wave[WV_H1].fall = pos_t'(32);
        t.wave[WV_H1].inv  = 1'b0;
        t.wave[WV_H2].rise = pos_t'(32);
        t.wave[WV_H2].fall = pos_t'(0);
        t.wave[WV_H2].inv  = 1'b0;
        t.shp = pos_t'(24);
        t.shd = pos_t'(56);
        return t;
    endfunction

    function automatic logic wave_level(pos_t ph, wave_t w);
        logic on;
        if (w.rise < w.fall)      on = (ph >= w.rise) && (ph < w.fall);
        else if (w.rise > w.fall) on = (ph >= w.rise) || (ph < w.fall);
        else                      on = 1'b0;
        return on ^ w.inv;
    endfunction
endpackage

// File: rtl/pxt_phase_ctr.sv
module pxt_phase_ctr
    import pxt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic div2_en,
    output pos_t phase,
    output logic adv,
    output logic wrap
);
    logic tog;

    assign adv  = !div2_en || tog;
    assign wrap = adv && (phase == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            tog   <= 1'b0;
        end else begin
            tog <= div2_en ? !tog : 1'b0;
            if (adv) phase <= phase + 1'b1;
        end
    end

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == '0));

    assert_half_rate_R10: assert property (@(posedge clk) disable iff (rst)
        (div2_en && adv) ##1 div2_en |-> !adv);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(phase));
endmodule

// File: rtl/pxt_cfg_bank.sv
module pxt_cfg_bank
    import pxt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  pos_t              wr_data,
    input  logic              commit,
    output timing_t           live
);
    timing_t staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= reset_timing();
            live   <= reset_timing();
        end else begin
            if (commit) live <= staged;
            if (wr_en) begin
                case (wr_addr)
                    A_RG_RISE: staged.wave[WV_RG].rise <= wr_data;
                    A_RG_FALL: staged.wave[WV_RG].fall <= wr_data;
                    A_H1_RISE: staged.wave[WV_H1].rise <= wr_data;
                    A_H1_FALL: staged.wave[WV_H1].fall <= wr_data;
                    A_H2_RISE: staged.wave[WV_H2].rise <= wr_data;
                    A_H2_FALL: staged.wave[WV_H2].fall <= wr_data;
                    A_SHP:     staged.shp <= wr_data;
                    A_SHD:     staged.shd <= wr_data;
                    A_POL: begin
                        for (int i = 0; i < NCLK; i++)
                            staged.wave[i].inv <= wr_data[i];
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_live_held_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live));
endmodule

// File: rtl/pxt_timing_gen.sv
module pxt_timing_gen
    import pxt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              div2_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PHASE_W-1:0] wr_data,
    output logic              rg,
    output logic              h1,
    output logic              h2,
    output logic              h3,
    output logic              h4,
    output logic              shp,
    output logic              shd,
    output logic              pix_start
);
    pos_t      phase;
    logic      adv;
    logic      wrap;
    timing_t   live;
    logic [NCLK-1:0] lvl;

    pxt_phase_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .div2_en (div2_en),
        .phase   (phase),
        .adv     (adv),
        .wrap    (wrap)
    );

    pxt_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (wrap),
        .live    (live)
    );

    for (genvar g = 0; g < NCLK; g++) begin : g_wave
        assign lvl[g] = wave_level(phase, live.wave[g]);
    end

    assign rg        = lvl[WV_RG];
    assign h1        = lvl[WV_H1];
    assign h2        = lvl[WV_H2];
    assign h3        = lvl[WV_H1];
    assign h4        = lvl[WV_H2];
    assign shp       = (phase == live.shp);
    assign shd       = (phase == live.shd);
    assign pix_start = (phase == '0);

    assert_marker_one_slot_R1: assert property (@(posedge clk) disable iff (rst)
        (pix_start && adv) |=> !pix_start);

    assert_shp_one_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (shp && adv && phase != LAST_POS) |=> !shp);

    assert_shd_one_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (shd && adv && phase != LAST_POS) |=> !shd);
endmodule

// File: tb/pxt_timing_gen_test.sv
`timescale 1ns/1ps
module pxt_timing_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic div2_en = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic rg, h1, h2, h3, h4, shp, shd, pix_start;

    int checks = 0;
    int errors = 0;
    string tag = "R2 reset";

    typedef struct {
        logic [7:0] v;
        string      t;
    } exp_t;
    exp_t q[$];

    int m_ph, m_tog;
    int s_r[3], s_f[3], a_r[3], a_f[3];
    bit s_i[3], a_i[3];
    int s_shp, s_shd, a_shp, a_shd;

    always #2.5 clk = ~clk;

    pxt_timing_gen uut (
        .clk(clk), .rst(rst), .div2_en(div2_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rg(rg), .h1(h1), .h2(h2),
        .h3(h3), .h4(h4), .shp(shp), .shd(shd), .pix_start(pix_start)
    );

    function automatic bit lv(int ph, int r, int f, bit inv);
        bit on;
        if (r < f)      on = (ph >= r) && (ph < f);
        else if (r > f) on = (ph >= r) || (ph < f);
        else            on = 1'b0;
        return on ^ inv;
    endfunction

    task automatic model_defaults();
        s_r = '{0, 0, 32}; s_f = '{8, 32, 0}; s_i = '{0, 0, 0};
        s_shp = 24; s_shd = 56;
        a_r = s_r; a_f = s_f; a_i = s_i; a_shp = s_shp; a_shd = s_shd;
        m_ph = 0; m_tog = 0;
    endtask

    task automatic model_write(int a, int d);
        if (a <= 5) begin
            if (a % 2 == 0) s_r[a/2] = d; else s_f[a/2] = d;
        end else if (a == 6) s_shp = d;
        else if (a == 7) s_shd = d;
        else if (a == 8) for (int i = 0; i < 3; i++) s_i[i] = d[i];
    endtask

    // driver: applies one cycle of stimulus, advances the model, queues the expectation
    task automatic step(bit r, bit d, bit w, int a, int dat);
        exp_t e;
        bit adv;
        @(negedge clk);
        rst = r; div2_en = d; wr_en = w;
        wr_addr = a[3:0]; wr_data = dat[5:0];
        if (r) model_defaults();
        else begin
            adv = !d || (m_tog != 0);
            m_tog = d ? (m_tog == 0 ? 1 : 0) : 0;
            if (adv) begin
                if (m_ph == 63) begin
                    a_r = s_r; a_f = s_f; a_i = s_i; a_shp = s_shp; a_shd = s_shd;
                end
                m_ph = (m_ph + 1) % 64;
            end
            if (w) model_write(a, dat);
        end
        e.v[0] = lv(m_ph, a_r[0], a_f[0], a_i[0]);
        e.v[1] = lv(m_ph, a_r[1], a_f[1], a_i[1]);
        e.v[2] = lv(m_ph, a_r[2], a_f[2], a_i[2]);
        e.v[3] = e.v[1];
        e.v[4] = e.v[2];
        e.v[5] = (m_ph == a_shp);
        e.v[6] = (m_ph == a_shd);
        e.v[7] = (m_ph == 0);
        e.t = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n, bit d);
        for (int i = 0; i < n; i++) step(0, d, 0, 0, 0);
    endtask

    task automatic wr(int a, int d);
        step(0, 0, 1, a, d);
    endtask

    function automatic void cmp(string sig, string req, logic got, logic exp, string t);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s [%s] got %b expected %b at %0t", req, sig, t, got, exp, $time);
        end
    endfunction

    // monitor: pops one expectation per cycle, after the edge has settled
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            cmp("rg",  "R3/R4/R5/R6", rg,  e.v[0], e.t);
            cmp("h1",  "R3/R4/R5/R6", h1,  e.v[1], e.t);
            cmp("h2",  "R3/R4/R5/R6", h2,  e.v[2], e.t);
            cmp("h3",  "R7", h3,  e.v[3], e.t);
            cmp("h4",  "R7", h4,  e.v[4], e.t);
            cmp("shp", "R8", shp, e.v[5], e.t);
            cmp("shd", "R8", shd, e.v[6], e.t);
            cmp("pix_start", "R1", pix_start, e.v[7], e.t);
        end
    end

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_defaults();
        tag = "R2 reset";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
        tag = "R1 R2 defaults";
        idle(70, 0);

        tag = "R3 R9 staged RG pulse";
        wr(0, 10); wr(1, 20);
        idle(130, 0);

        tag = "R4 R5 wrap and equal";
        wr(2, 50); wr(3, 5); wr(4, 17); wr(5, 17);
        idle(130, 0);

        tag = "R6 R7 polarity";
        wr(8, 7);
        idle(130, 0);
        wr(8, 2);
        idle(70, 0);

        tag = "R8 edge strobes";
        wr(6, 0); wr(7, 63);
        idle(130, 0);

        tag = "R9 write on commit edge";
        while (m_ph != 63) idle(1, 0);
        wr(6, 40);
        idle(140, 0);

        tag = "R11 unmapped addresses";
        for (int a = 9; a < 16; a++) wr(a, 63);
        wr(7, 5);
        idle(130, 0);

        tag = "R10 divide by two";
        idle(150, 1);
        step(0, 1, 1, 0, 3);
        step(0, 1, 1, 1, 60);
        idle(300, 1);

        tag = "R1 back to full rate";
        idle(70, 0);

        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule